// File: doc/BRIEF.md
# Flash Controller Protected Control Registers

This block holds two byte-wide control and status registers for an embedded flash controller. They sit on a simple single-cycle CPU register bus. Writes to some enable bits are guarded: a bit goes to 1 only when a write of 1 comes straight after a write of 0 to the same bit, with no bus transfer between the two. Other enable bits depend on the rewrite-mode bit, or are cleared along with it. The block reports the sequencer's ready/busy state and holds sticky program and erase error flags. A clear-status command input clears those flags.

The stop bit puts the flash array into reset and blocks access to it. When the stop ends, access stays blocked for a set number of clock cycles. A wait-state output adds exactly one wait to accesses that hit the two small data blocks when the block-wait bit is set. All other accesses follow a global wait input. The flash array and its program/erase sequencer are outside this block and appear only as input strobes.

Top module: `flash_ctl_regs`

## Requirements
- R1: After reset, control register 0 (address 0x1B7) reads 0x01 while the sequencer is idle, control register 1 (address 0x1B5) reads 0x00, and `flash_access_ok` is 1.
- R2: Register 0 bit 0 reads as the inverse of `seq_busy`, and writes to it are ignored.
- R3: Register 0 bit 1 (rewrite mode) becomes 1 only when a CPU write with that bit at 1 directly follows a CPU write to register 0 with that bit at 0. Any bus transaction in between breaks the pair: a read, a write to another address, or a DMA-tagged access. A write with bit 1 at 0 clears the bit.
- R4: Register 0 bit 2 (low-block rewrite enable) uses the same write-0-then-write-1 pair. It can become 1 only while bit 1 is already 1. A write with bit 2 at 0 clears it.
- R5: Register 1 bit 1 (erase-write mode select) uses the write-0-then-write-1 pair and can become 1 only while register 0 bit 1 is 1. A write that clears register 0 bit 1 also clears register 1 bit 1.
- R6: Register 1 bit 6 (four-block rewrite enable) becomes 1 only through the write-0-then-write-1 pair. A write with it at 0 clears it.
- R7: Register 0 bit 3 (stop) is stored on any CPU write. `flash_stop` is 1 only while both bit 3 and register 0 bit 1 are 1. While `flash_stop` is 1, `flash_access_ok` is 0.
- R8: After `flash_stop` falls, `flash_access_ok` stays 0 for exactly RECOV_CYC clock cycles and then returns to 1.
- R9: Register 0 bit 6 is set by `prog_fail` and bit 7 by `erase_fail`. Both are cleared by `clear_status`. A strobe in the same cycle as `clear_status` wins, so the flag ends up 1.
- R10: `wait_req` is 1 whenever `ab_access` is 1 and register 1 bit 7 is 1. Otherwise `wait_req` equals `global_wait`.
- R11: Register 0 bits 5:4 and register 1 bits 5:2 and 0 ignore writes and read 0. DMA-tagged accesses never change register bits and read back 0. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus transaction present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_dma | input | 1 | Transaction issued by DMA |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| seq_busy | input | 1 | Program/erase sequencer busy |
| prog_fail | input | 1 | Program error strobe |
| erase_fail | input | 1 | Erase error strobe |
| clear_status | input | 1 | Clear-status command strobe |
| ab_access | input | 1 | Current flash access targets data block A or B |
| global_wait | input | 1 | Global wait-state request |
| wait_req | output | 1 | One-wait request for the current access |
| flash_stop | output | 1 | Hold flash array in reset / low power |
| flash_access_ok | output | 1 | Flash reads permitted |

## Verification
Two events can fall in the same cycle: an error strobe and a clear-status command. Both also compete with the unlock pair, because the pair's second write may land in the cycle the stop recovery counter is still running. The bench drives `prog_fail` or `erase_fail` in the same cycle as `clear_status` and then reads register 0, expecting the flag to be set. Random cycles also overlap strobes, clears, unlock pairs and stop releases. Every register read and every `flash_access_ok` value is judged against a reference model in the bench that counts the recovery cycles itself.

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] R0_ADDR = 10'h1B7,
  parameter logic [ADDR_W-1:0] R1_ADDR = 10'h1B5,
  parameter int RECOV_CYC = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_dma,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              seq_busy,
  input  logic              prog_fail,
  input  logic              erase_fail,
  input  logic              clear_status,
  input  logic              ab_access,
  input  logic              global_wait,
  output logic              wait_req,
  output logic              flash_stop,
  output logic              flash_access_ok
);
  localparam int CW = $clog2(RECOV_CYC + 1);

  logic rw_en, blk01_en, stop_bit, perr, eerr;
  logic ew1_sel, blk03_en, ab_wait;
  logic arm_rw, arm_b01, arm_ew, arm_b03;
  logic [CW-1:0] recov_cnt;
  logic unused_bits;

  wire cpu_acc = bus_valid & ~bus_dma;
  wire wr0 = cpu_acc & bus_write & (bus_addr == R0_ADDR);
  wire wr1 = cpu_acc & bus_write & (bus_addr == R1_ADDR);
  wire rd0 = cpu_acc & ~bus_write & (bus_addr == R0_ADDR);
  wire rd1 = cpu_acc & ~bus_write & (bus_addr == R1_ADDR);

  wire [7:0] reg0 = {eerr, perr, 2'b00, stop_bit, blk01_en, rw_en, ~seq_busy};
  wire [7:0] reg1 = {ab_wait, blk03_en, 4'b0000, ew1_sel, 1'b0};

  assign bus_rdata = rd0 ? reg0 : (rd1 ? reg1 : 8'h00);
  assign flash_stop = stop_bit & rw_en;
  assign flash_access_ok = ~flash_stop & (recov_cnt == '0);
  assign wait_req = (ab_access & ab_wait) | global_wait;
  assign unused_bits = ^{bus_wdata[5:4], bus_wdata[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_rw  <= 1'b0;
      arm_b01 <= 1'b0;
      arm_ew  <= 1'b0;
      arm_b03 <= 1'b0;
    end else if (bus_valid) begin
      arm_rw  <= wr0 & ~bus_wdata[1];
      arm_b01 <= wr0 & ~bus_wdata[2];
      arm_ew  <= wr1 & ~bus_wdata[1];
      arm_b03 <= wr1 & ~bus_wdata[6];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rw_en    <= 1'b0;
      blk01_en <= 1'b0;
      stop_bit <= 1'b0;
    end else if (wr0) begin
      if (!bus_wdata[1])  rw_en <= 1'b0;
      else if (arm_rw)    rw_en <= 1'b1;
      if (!bus_wdata[2])  blk01_en <= 1'b0;
      else if (arm_b01 && rw_en) blk01_en <= 1'b1;
      stop_bit <= bus_wdata[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ew1_sel  <= 1'b0;
      blk03_en <= 1'b0;
      ab_wait  <= 1'b0;
    end else if (wr0) begin
      if (!bus_wdata[1]) ew1_sel <= 1'b0;
    end else if (wr1) begin
      if (!bus_wdata[1])            ew1_sel <= 1'b0;
      else if (arm_ew && rw_en)     ew1_sel <= 1'b1;
      if (!bus_wdata[6])            blk03_en <= 1'b0;
      else if (arm_b03)             blk03_en <= 1'b1;
      ab_wait <= bus_wdata[7];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perr <= 1'b0;
      eerr <= 1'b0;
    end else begin
      if (prog_fail)         perr <= 1'b1;
      else if (clear_status) perr <= 1'b0;
      if (erase_fail)        eerr <= 1'b1;
      else if (clear_status) eerr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              recov_cnt <= '0;
    else if (flash_stop)     recov_cnt <= CW'(RECOV_CYC);
    else if (recov_cnt != 0) recov_cnt <= recov_cnt - 1'b1;
  end
endmodule

module flash_ctl_regs_chk #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] R0_ADDR = 10'h1B7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              bus_dma,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              rw_en,
  input logic              blk01_en,
  input logic              ew1_sel,
  input logic              perr,
  input logic              prog_fail,
  input logic              ab_access,
  input logic              ab_wait,
  input logic              wait_req,
  input logic              flash_stop,
  input logic              flash_access_ok
);
  // R3
  rw_set_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rw_en) |-> $past(bus_valid && bus_write && !bus_dma &&
                           bus_addr == R0_ADDR && bus_wdata[1]));
  // R4
  blk01_needs_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk01_en) |-> $past(rw_en));
  // R5
  ew1_under_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_en |-> !ew1_sel);
  // R7
  stop_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_stop |-> !flash_access_ok);
  // R8
  recovery_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_stop) |-> !flash_access_ok);
  // R9
  strobe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(prog_fail) |-> perr);
  // R10
  ab_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_access && ab_wait) |-> wait_req);
endmodule

bind flash_ctl_regs flash_ctl_regs_chk #(.ADDR_W(ADDR_W), .R0_ADDR(R0_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_dma(bus_dma), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .rw_en(rw_en), .blk01_en(blk01_en), .ew1_sel(ew1_sel), .perr(perr),
  .prog_fail(prog_fail), .ab_access(ab_access), .ab_wait(ab_wait),
  .wait_req(wait_req), .flash_stop(flash_stop), .flash_access_ok(flash_access_ok)
);

// File: tb/sim_flash_ctl_regs.sv
module sim_flash_ctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int RECOV = 12;
  localparam logic [9:0] A0 = 10'h1B7, A1 = 10'h1B5, AX = 10'h1B6;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, bus_dma = 0;
  logic [9:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic seq_busy = 0, prog_fail = 0, erase_fail = 0, clear_status = 0;
  logic ab_access = 0, global_wait = 0;
  logic wait_req, flash_stop, flash_access_ok;
  int checks = 0, fails = 0;
  bit done = 0;

  bit m_rw, m_b01, m_stop, m_perr, m_eerr, m_ew1, m_b03, m_abw;
  bit a_rw, a_b01, a_ew, a_b03;
  int m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_ctl_regs #(.RECOV_CYC(RECOV)) u0 (.*);

  function automatic logic [7:0] exp_r0();
    return {m_eerr, m_perr, 2'b00, m_stop, m_b01, m_rw, ~seq_busy};
  endfunction
  function automatic logic [7:0] exp_r1();
    return {m_abw, m_b03, 4'b0000, m_ew1, 1'b0};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit w0, w1, orw;
    w0 = bus_valid & bus_write & ~bus_dma & (bus_addr == A0);
    w1 = bus_valid & bus_write & ~bus_dma & (bus_addr == A1);
    orw = m_rw;
    if (m_stop && m_rw) m_cnt = RECOV; else if (m_cnt > 0) m_cnt--;
    if (w0) begin
      if (!bus_wdata[1]) begin m_rw = 0; m_ew1 = 0; end
      else if (a_rw) m_rw = 1;
      if (!bus_wdata[2]) m_b01 = 0; else if (a_b01 && orw) m_b01 = 1;
      m_stop = bus_wdata[3];
    end
    if (w1) begin
      if (!bus_wdata[1]) m_ew1 = 0; else if (a_ew && orw) m_ew1 = 1;
      if (!bus_wdata[6]) m_b03 = 0; else if (a_b03) m_b03 = 1;
      m_abw = bus_wdata[7];
    end
    if (prog_fail) m_perr = 1; else if (clear_status) m_perr = 0;
    if (erase_fail) m_eerr = 1; else if (clear_status) m_eerr = 0;
    if (bus_valid) begin
      a_rw = w0 & ~bus_wdata[1]; a_b01 = w0 & ~bus_wdata[2];
      a_ew = w1 & ~bus_wdata[1]; a_b03 = w1 & ~bus_wdata[6];
    end
  endtask

  task automatic cyc(bit v, bit w, bit d, logic [9:0] a, logic [7:0] wd, string tag);
    logic [7:0] er;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_dma = d; bus_addr = a; bus_wdata = wd;
    #1;
    er = 8'h00;
    if (v && !w && !d && a == A0) er = exp_r0();
    if (v && !w && !d && a == A1) er = exp_r1();
    chk(tag, bus_rdata, er);
    chk("R7", {7'b0, flash_stop}, {7'b0, m_stop & m_rw});
    chk("R8", {7'b0, flash_access_ok}, {7'b0, !(m_stop && m_rw) && m_cnt == 0});
    chk("R10", {7'b0, wait_req}, {7'b0, (ab_access & m_abw) | global_wait});
    @(posedge clk);
    model_step();
    #1;
    prog_fail = 0; erase_fail = 0; clear_status = 0;
  endtask

  task automatic wr(logic [9:0] a, logic [7:0] d, string tag); cyc(1, 1, 0, a, d, tag); endtask
  task automatic rd(logic [9:0] a, string tag); cyc(1, 0, 0, a, 8'h00, tag); endtask
  task automatic idle(); cyc(0, 0, 0, AX, 8'h00, "R11"); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1", {7'b0, flash_access_ok}, 8'h01);
    rd(A0, "R1"); chk("R1", exp_r0(), 8'h01);
    rd(A1, "R1");
    // R2
    seq_busy = 1; rd(A0, "R2"); seq_busy = 0; wr(A0, 8'h01, "R2"); rd(A0, "R2");
    // R3 single 1 ignored, pair sets, breaks
    wr(A0, 8'h02, "R3"); rd(A0, "R3"); chk("R3", {7'b0, m_rw}, 8'h00);
    wr(A0, 8'h00, "R3"); rd(A0, "R3"); wr(A0, 8'h02, "R3"); rd(A0, "R3");
    wr(A0, 8'h00, "R3"); cyc(1, 1, 1, A0, 8'h00, "R3"); wr(A0, 8'h02, "R3"); rd(A0, "R3");
    wr(A0, 8'h00, "R3"); wr(AX, 8'h00, "R3"); wr(A0, 8'h02, "R3"); rd(A0, "R3");
    wr(A0, 8'h00, "R3"); idle(); wr(A0, 8'h02, "R3"); rd(A0, "R3");
    chk("R3", {7'b0, m_rw}, 8'h01);
    // R4
    wr(A0, 8'h00, "R4"); wr(A0, 8'h04, "R4"); rd(A0, "R4");
    wr(A0, 8'h00, "R4"); wr(A0, 8'h02, "R4"); wr(A0, 8'h02, "R4"); wr(A0, 8'h06, "R4"); rd(A0, "R4");
    chk("R4", {7'b0, m_b01}, 8'h01);
    // R5
    wr(A1, 8'h00, "R5"); wr(A1, 8'h02, "R5"); rd(A1, "R5");
    wr(A0, 8'h04, "R5"); rd(A1, "R5"); rd(A0, "R5");
    wr(A1, 8'h00, "R5"); wr(A1, 8'h02, "R5"); rd(A1, "R5");
    // R6
    wr(A1, 8'h40, "R6"); rd(A1, "R6"); wr(A1, 8'h00, "R6"); wr(A1, 8'h40, "R6"); rd(A1, "R6");
    // R7 / R8
    wr(A0, 8'h08, "R7"); idle(); rd(A0, "R7");
    wr(A0, 8'h0A, "R7"); wr(A0, 8'h08, "R7"); wr(A0, 8'h0A, "R7"); idle(); idle();
    wr(A0, 8'h02, "R8");
    for (int i = 0; i < RECOV + 3; i++) idle();
    // R9 strobe vs clear in the same cycle
    prog_fail = 1; clear_status = 1; idle(); rd(A0, "R9");
    erase_fail = 1; idle(); rd(A0, "R9");
    clear_status = 1; idle(); rd(A0, "R9");
    erase_fail = 1; clear_status = 1; idle(); rd(A0, "R9");
    // R10
    wr(A1, 8'h80, "R10"); ab_access = 1; global_wait = 0; idle();
    ab_access = 0; idle(); global_wait = 1; idle();
    wr(A1, 8'h00, "R10"); ab_access = 1; global_wait = 0; idle();
    // R11
    wr(A0, 8'h32, "R11"); rd(A0, "R11"); wr(A1, 8'h3D, "R11"); rd(A1, "R11");
    cyc(1, 1, 1, A1, 8'h80, "R11"); rd(A1, "R11"); cyc(1, 0, 1, A0, 8'h00, "R11");
    rd(AX, "R11");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [9:0] a;
      r = $urandom_range(0, 99);
      a = (r < 45) ? A0 : (r < 85) ? A1 : AX;
      seq_busy = ($urandom_range(0, 3) == 0);
      prog_fail = ($urandom_range(0, 15) == 0);
      erase_fail = ($urandom_range(0, 15) == 0);
      clear_status = ($urandom_range(0, 7) == 0);
      ab_access = $urandom_range(0, 1);
      global_wait = ($urandom_range(0, 3) == 0);
      r = $urandom_range(0, 99);
      if (r < 25) begin
        logic [7:0] d;
        d = 8'($urandom);
        wr(a, d & 8'hB9, "R3");
        wr(a, d | 8'h46, "R6");
      end else if (r < 35) idle();
      else cyc(1, r < 70, $urandom_range(0, 9) == 0, a, 8'($urandom), "R4");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule